// File: doc/BRIEF.md
# Switchable-Width Byte-Lane Static Memory Core

This block is a clocked, synthesizable model of a static memory. It can present its storage as 16-bit words or as 8-bit bytes, and a mode pin chooses between the two. Two chip enables select the part: `ce1_n` is active low and `ce2` is active high. An output enable, a write enable and two active-low byte-lane controls then decide whether a cycle is idle, output-disabled, a read or a write. The shared bidirectional data bus is split into three parts: an input bus, an output bus, and per-lane flags that say which lane would be driving. Each lane also reports when it is being written.

In word mode, `addr` selects a word, and the lower and upper lane controls gate bits 7:0 and 15:8 separately. In byte mode, `byte_sel` is appended below `addr` as the least-significant address bit. Only the lower lane carries data, and the lane controls are ignored. Every input is sampled on the rising clock edge. A write lands at that edge. Read data, drive flags and write flags appear on the registered outputs one cycle after the edge that sampled them.

The pin interface is a memory pin interface, not a stream. It has no handshake and no back-pressure. Every cycle is accepted, and every cycle produces exactly one registered result on the following cycle.

Top module: `sram_dw_core`

## Requirements
- R1: When `ce1_n` is high or `ce2` is low, the core is in standby. One cycle later, `lane_drive`, `lane_write` and `rdata` are all zero, and no stored byte changes.
- R2: In word mode (`word_mode`=1), having both `lo_n` and `hi_n` high counts as deselected, with the same results as R1.
- R3: In word mode, a read is a cycle that is selected with `we_n`=1 and `oe_n`=0. One cycle later, `lane_drive` shows the enabled lanes: bit 0 is bits 7:0, enabled by `lo_n`=0, and bit 1 is bits 15:8, enabled by `hi_n`=0. `rdata` carries the stored bytes on the enabled lanes and zero on the others.
- R4: A selected cycle with `we_n`=1 and `oe_n`=1 is an output-disable cycle. One cycle later, `lane_drive`, `lane_write` and `rdata` are zero.
- R5: In word mode, a selected cycle with `we_n`=0 is a write, whatever the level of `oe_n`. It stores `wdata` only into the enabled lanes of word `addr`. One cycle later, `lane_write` equals the enabled-lane pattern and `lane_drive` is zero.
- R6: In byte mode (`word_mode`=0), a write stores `wdata[7:0]` into byte `{addr, byte_sel}`. `byte_sel`=0 selects bits 7:0 of word `addr` and `byte_sel`=1 selects bits 15:8. The other half keeps its value. The write reports `lane_write`=01.
- R7: In byte mode, a read returns the selected byte on `rdata[7:0]` with `lane_drive`=01. `rdata[15:8]` is zero, and `lo_n`/`hi_n` have no effect, even when both are high.
- R8: While `rst_n` is low, and on the first cycle after it rises, `rdata`, `lane_drive` and `lane_write` are zero.
- R9: A write commits on every cycle whose write conditions hold. Back-to-back writes to different addresses all land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low reset of the output registers |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| word_mode | input | 1 | 1 = 16-bit word organization, 0 = byte organization |
| lo_n | input | 1 | Lower lane (bits 7:0) enable, active low, word mode only |
| hi_n | input | 1 | Upper lane (bits 15:8) enable, active low, word mode only |
| addr | input | ADDR_W | Word address |
| byte_sel | input | 1 | Byte-mode least-significant address bit |
| wdata | input | 2*LANE_W | Write data |
| rdata | output | 2*LANE_W | Registered read data, zero on lanes not driving |
| lane_drive | output | 2 | Per-lane output-enable flags, bit 0 = lower lane |
| lane_write | output | 2 | Per-lane write flags for the cycle just committed |

## Verification
A wrong lane decode or mode decode shows on `lane_drive` or `lane_write` on the cycle right after the faulty input cycle, because those flags are registered straight from the decode. A wrong bank write enable, or wrong write-data steering, corrupts a stored byte without any immediate sign. It becomes visible only when that byte is read back: on `rdata` one cycle after that read, either as a wrong value or as a changed neighbour half after a byte write. The random mix therefore reads the memory continuously after a full pre-fill, so corrupted bytes surface within a few hundred cycles.

// File: rtl/sram_dw_pkg.sv
package sram_dw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_HIZ  = 2'd1,
    OP_RD   = 2'd2,
    OP_WR   = 2'd3
  } op_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/sram_dw_decode.sv
module sram_dw_decode
  import sram_dw_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ce1_n,
  input  logic                              ce2,
  input  logic                              oe_n,
  input  logic                              we_n,
  input  logic                              word_mode,
  input  logic                              lo_n,
  input  logic                              hi_n,
  input  logic                              byte_sel,
  input  logic [NUM_LANES*LANE_W-1:0]       wdata,
  output op_e                               op_o,
  output logic [NUM_LANES-1:0]              lane_en_o,
  output logic [NUM_LANES-1:0]              bank_we_o,
  output logic [NUM_LANES-1:0][LANE_W-1:0]  bank_wd_o
);
  logic chip_on;
  logic lanes_any;

  // Lane pattern: word mode follows the active-low controls, byte mode forces lane 0.
  always_comb begin
    if (word_mode) lane_en_o = {~hi_n, ~lo_n};
    else           lane_en_o = {{(NUM_LANES-1){1'b0}}, 1'b1};
  end

  assign lanes_any = |lane_en_o;
  assign chip_on   = ~ce1_n & ce2 & lanes_any;

  always_comb begin
    if (!chip_on)   op_o = OP_IDLE;
    else if (!we_n) op_o = OP_WR;
    else if (!oe_n) op_o = OP_RD;
    else            op_o = OP_HIZ;
  end

  // Bank write enables and write-data steering, one per storage half.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_steer
    always_comb begin
      if (word_mode) begin
        bank_we_o[g] = (op_o == OP_WR) & lane_en_o[g];
        bank_wd_o[g] = wdata[g*LANE_W +: LANE_W];
      end else begin
        bank_we_o[g] = (op_o == OP_WR) & (byte_sel == g[0]);
        bank_wd_o[g] = wdata[LANE_W-1:0];
      end
    end
  end

  // R6: a byte-mode write touches at most one half of the word.
  p_byte_one_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> $onehot0(bank_we_o));

  // R1: no bank is written while a chip enable is inactive.
  p_standby_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n || !ce2) |-> (bank_we_o == '0));

  // R2: both lane controls high in word mode never write.
  p_word_both_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && lo_n && hi_n) |-> (bank_we_o == '0));
endmodule

// File: rtl/sram_dw_bank.sv
module sram_dw_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wd_i,
  output logic [W-1:0]      rd_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wd_i;
  end

  assign rd_o = mem[addr_i];

  // R5: a write enable lands the write data at that address.
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem[$past(addr_i)] == $past(wd_i)));

  // R1: with no write enable the addressed byte is unchanged.
  p_hold_no_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> (mem[$past(addr_i)] == $past(rd_o)));
endmodule

// File: rtl/sram_dw_rdstage.sv
module sram_dw_rdstage
  import sram_dw_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  op_e                               op_i,
  input  logic                              word_mode_i,
  input  logic                              byte_sel_i,
  input  logic [NUM_LANES-1:0]              lane_en_i,
  input  logic [NUM_LANES-1:0][LANE_W-1:0]  bank_rd_i,
  output logic [NUM_LANES*LANE_W-1:0]       rdata_o,
  output logic [NUM_LANES-1:0]              drive_o,
  output logic [NUM_LANES-1:0]              write_o
);
  logic [NUM_LANES*LANE_W-1:0] rdata_nxt;
  logic [NUM_LANES-1:0]        drive_nxt;
  logic [NUM_LANES-1:0]        write_nxt;

  assign drive_nxt = (op_i == OP_RD) ? lane_en_i : '0;
  assign write_nxt = (op_i == OP_WR) ? lane_en_i : '0;

  always_comb begin
    rdata_nxt = '0;
    if (op_i == OP_RD) begin
      if (word_mode_i) begin
        for (int i = 0; i < NUM_LANES; i++) begin
          if (lane_en_i[i]) rdata_nxt[i*LANE_W +: LANE_W] = bank_rd_i[i];
        end
      end else begin
        rdata_nxt[LANE_W-1:0] = bank_rd_i[byte_sel_i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      drive_o <= '0;
      write_o <= '0;
    end else begin
      rdata_o <= rdata_nxt;
      drive_o <= drive_nxt;
      write_o <= write_nxt;
    end
  end

  // R7: byte mode never drives the upper lane.
  p_byte_upper_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode_i |=> (!drive_o[NUM_LANES-1] && rdata_o[NUM_LANES*LANE_W-1:LANE_W] == '0));

  // R1: an idle decode leaves every lane quiet next cycle.
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IDLE) |=> (drive_o == '0 && write_o == '0 && rdata_o == '0));

  // R4: output-disable cycles leave every lane quiet next cycle.
  p_hiz_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HIZ) |=> (drive_o == '0 && write_o == '0));
endmodule

// File: rtl/sram_dw_core.sv
module sram_dw_core
  import sram_dw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce1_n,
  input  logic                        ce2,
  input  logic                        oe_n,
  input  logic                        we_n,
  input  logic                        word_mode,
  input  logic                        lo_n,
  input  logic                        hi_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        byte_sel,
  input  logic [2*LANE_W-1:0]         wdata,
  output logic [2*LANE_W-1:0]         rdata,
  output logic [1:0]                  lane_drive,
  output logic [1:0]                  lane_write
);
  op_e                              op;
  logic [NUM_LANES-1:0]             lane_en;
  logic [NUM_LANES-1:0]             bank_we;
  logic [NUM_LANES-1:0][LANE_W-1:0] bank_wd;
  logic [NUM_LANES-1:0][LANE_W-1:0] bank_rd;

  sram_dw_decode #(.LANE_W(LANE_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .word_mode (word_mode),
    .lo_n      (lo_n),
    .hi_n      (hi_n),
    .byte_sel  (byte_sel),
    .wdata     (wdata),
    .op_o      (op),
    .lane_en_o (lane_en),
    .bank_we_o (bank_we),
    .bank_wd_o (bank_wd)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_bank
    sram_dw_bank #(.ADDR_W(ADDR_W), .W(LANE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (bank_we[g]),
      .addr_i (addr),
      .wd_i   (bank_wd[g]),
      .rd_o   (bank_rd[g])
    );
  end

  sram_dw_rdstage #(.LANE_W(LANE_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .word_mode_i (word_mode),
    .byte_sel_i  (byte_sel),
    .lane_en_i   (lane_en),
    .bank_rd_i   (bank_rd),
    .rdata_o     (rdata),
    .drive_o     (lane_drive),
    .write_o     (lane_write)
  );

  // R5: a lane that reports a write never drives in the same cycle.
  p_write_not_driving_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_write != '0) |-> (lane_drive == '0));

  // R3: a decoded read shows at least one driving lane one cycle later.
  p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD) |=> (lane_drive != '0));

  // R9: a decoded write always reports on the next cycle.
  p_write_reported_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR) |=> (lane_write != '0));
endmodule

// File: tb/test_sram_dw_core.sv
module test_sram_dw_core;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce1_n, ce2, oe_n, we_n, word_mode, lo_n, hi_n, byte_sel;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic [15:0]   rdata;
  logic [1:0]    lane_drive, lane_write;

  logic [15:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_dw_core #(.ADDR_W(AW), .LANE_W(8)) i_sram_dw_core (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .lo_n(lo_n), .hi_n(hi_n), .addr(addr), .byte_sel(byte_sel),
    .wdata(wdata), .rdata(rdata), .lane_drive(lane_drive), .lane_write(lane_write)
  );

  task automatic compare(string tag, logic [15:0] er, logic [1:0] ed, logic [1:0] ew);
    checks++;
    if (rdata !== er || lane_drive !== ed || lane_write !== ew) begin
      errors++;
      $display("FAIL %s: rdata=%h drive=%b write=%b expected rdata=%h drive=%b write=%b",
               tag, rdata, lane_drive, lane_write, er, ed, ew);
    end
  endtask

  // Apply one cycle of stimulus at a falling edge, predict, check at the next falling edge.
  task automatic step(logic c1n, logic c2, logic oen, logic wen, logic wm, logic lon,
                      logic hin, logic [AW-1:0] a, logic bs, logic [15:0] wd, string note);
    logic        sel;
    logic [1:0]  lanes;
    logic [15:0] er;
    logic [1:0]  ed, ew;
    string       tag;
    ce1_n = c1n; ce2 = c2; oe_n = oen; we_n = wen; word_mode = wm;
    lo_n = lon; hi_n = hin; addr = a; byte_sel = bs; wdata = wd;
    lanes = wm ? {~hin, ~lon} : 2'b01;
    sel   = ~c1n & c2 & (lanes != 2'b00);
    er = '0; ed = '0; ew = '0;
    if (!sel) begin
      tag = (~c1n & c2) ? "R2" : "R1";
    end else if (!wen) begin
      ew = lanes;
      if (wm) begin
        tag = "R5";
        if (lanes[0]) model[a][7:0]  = wd[7:0];
        if (lanes[1]) model[a][15:8] = wd[15:8];
      end else begin
        tag = "R6";
        if (bs) model[a][15:8] = wd[7:0];
        else    model[a][7:0]  = wd[7:0];
      end
    end else if (!oen) begin
      ed = lanes;
      if (wm) begin
        tag = "R3";
        if (lanes[0]) er[7:0]  = model[a][7:0];
        if (lanes[1]) er[15:8] = model[a][15:8];
      end else begin
        tag = "R7";
        er[7:0] = bs ? model[a][15:8] : model[a][7:0];
      end
    end else begin
      tag = "R4";
    end
    @(negedge clk);
    compare({tag, " ", note}, er, ed, ew);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    // Active read-like stimulus during reset must not reach the outputs.
    ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b1; word_mode = 1'b1;
    lo_n = 1'b0; hi_n = 1'b0; addr = '0; byte_sel = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    compare("R8 during reset", 16'h0, 2'b00, 2'b00);
    rst_n = 1'b1;
    ce1_n = 1'b1;
    @(negedge clk);
    compare("R8 after reset", 16'h0, 2'b00, 2'b00);

    // Pre-fill every word with full-width writes (R9 back-to-back).
    for (int i = 0; i < DEPTH; i++)
      step(0, 1, 1, 0, 1, 0, 0, AW'(i), 0, 16'($urandom), "R9 fill");
    for (int i = 0; i < DEPTH; i += 17)
      step(0, 1, 0, 1, 1, 0, 0, AW'(i), 0, 16'h0, "R9 readback");

    // Directed corners.
    step(1, 1, 0, 1, 1, 0, 0, 8'h10, 0, 16'h0, "ce1 off");
    step(0, 0, 0, 1, 1, 0, 0, 8'h10, 0, 16'h0, "ce2 off");
    step(1, 1, 0, 0, 1, 0, 0, 8'h10, 0, 16'hDEAD, "write while ce1 off");
    step(0, 0, 0, 0, 0, 0, 0, 8'h10, 1, 16'hBEEF, "byte write while ce2 off");
    step(0, 1, 0, 1, 1, 0, 0, 8'h10, 0, 16'h0, "R1 word unchanged");
    step(0, 1, 0, 0, 1, 1, 1, 8'h11, 0, 16'hAAAA, "both lanes off write");
    step(0, 1, 0, 1, 1, 0, 0, 8'h11, 0, 16'h0, "R2 word unchanged");
    step(0, 1, 1, 1, 1, 0, 0, 8'h12, 0, 16'h0, "output disable");
    step(0, 1, 0, 0, 1, 0, 1, 8'h13, 0, 16'h1234, "low-lane write, oe active");
    step(0, 1, 1, 0, 1, 1, 0, 8'h14, 0, 16'h5678, "high-lane write");
    step(0, 1, 0, 1, 1, 0, 0, 8'h13, 0, 16'h0, "R5 upper kept");
    step(0, 1, 0, 1, 1, 0, 0, 8'h14, 0, 16'h0, "R5 lower kept");
    step(0, 1, 0, 1, 1, 1, 0, 8'h14, 0, 16'h0, "upper-only read");
    step(0, 1, 1, 0, 0, 1, 1, 8'h20, 1, 16'hFFC3, "byte write upper half");
    step(0, 1, 1, 0, 0, 0, 0, 8'h21, 0, 16'hFF3C, "byte write lower half");
    step(0, 1, 0, 1, 1, 0, 0, 8'h20, 0, 16'h0, "R6 lower half kept");
    step(0, 1, 0, 1, 1, 0, 0, 8'h21, 0, 16'h0, "R6 upper half kept");
    step(0, 1, 0, 1, 0, 1, 1, 8'h20, 1, 16'h0, "R7 byte read, lane ctl high");
    step(0, 1, 0, 1, 0, 0, 1, 8'h21, 0, 16'h0, "R7 byte read, lower half");
    for (int i = 0; i < 6; i++)
      step(0, 1, 1, 0, 1, 0, 0, AW'(8'h40 + i), 0, 16'(16'h0A00 + i), "R9 burst");
    for (int i = 0; i < 6; i++)
      step(0, 1, 0, 1, 1, 0, 0, AW'(8'h40 + i), 0, 16'h0, "R9 burst check");

    // Constrained random mix.
    for (int n = 0; n < 6000; n++) begin
      step($urandom_range(7) == 0, $urandom_range(7) != 0, $urandom_range(1) == 1,
           $urandom_range(2) == 0, $urandom_range(3) != 0, $urandom_range(3) == 0,
           $urandom_range(3) == 0, AW'($urandom), $urandom_range(1) == 1,
           16'($urandom), "random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule